// File: doc/BRIEF.md
# Nibble Accumulator ALU with Decimal Adjust

This block is the arithmetic heart of a small accumulator-based controller working on 4-bit data. From the accumulator, a second operand (a memory nibble or an immediate supplied by the surrounding datapath), the carry flag and an operation code, it forms the result nibble, the carry value to be written together with a write enable, a zero indication for the zero and non-zero branch tests, and one selected accumulator bit for the jump-on-bit test.

The combinational path covers addition and subtraction with and without carry, the three bitwise operations, increment and decrement, four rotate forms and the decimal adjust that follows a BCD addition. A thin registered wrapper holds the accumulator and the carry flag: when `exec_i` is high the result and, where enabled, the new carry are captured on the next rising clock edge. Fetching operands, the register file, memory and instruction decode sit outside the block.

Top module: `nib_acc_alu`

## Requirements
- R1: While `rst_n` is low and after it is released until the first executed operation, `acc_o` reads 0 and `cf_o` reads 0.
- R2: Op code 0 (add) yields acc+opnd and op code 1 (add with carry) yields acc+opnd+cf, both modulo 16, with the carry out of bit 3 as the new carry and `cf_we_o` high.
- R3: Op code 2 (subtract) yields acc+~opnd+1 and op code 3 (subtract with borrow) yields acc+~opnd+cf, modulo 16; the new carry is 1 when no borrow occurs (the sum carries out of bit 3) and 0 otherwise, with `cf_we_o` high.
- R4: Op codes 4, 5 and 6 yield acc AND, OR and XOR opnd respectively, keep `cf_we_o` low and leave `cf_o` unchanged after execution.
- R5: Op code 7 yields acc+1 and op code 8 yields acc-1, both wrapping modulo 16, with `cf_we_o` low so the carry is untouched.
- R6: Op code 9 rotates left, putting old bit 3 into both bit 0 and the carry; op code 11 rotates right, putting old bit 0 into both bit 3 and the carry; both write the carry.
- R7: Op code 10 rotates left through the carry (old carry into bit 0, old bit 3 into carry); op code 12 rotates right through the carry (old carry into bit 3, old bit 0 into carry).
- R8: Op code 13 (decimal adjust) adds 6 modulo 16 and writes carry 1 when acc is greater than 9 or the carry is 1; otherwise the result equals acc and `cf_we_o` is low, so a set carry is never cleared.
- R9: `zero_o` is high exactly when `result_o` is 0000.
- R10: `bit_o` equals acc bit number `bit_sel_i` (0 to 3) for every operation.
- R11: With `exec_i` high, `acc_o` takes `result_o` and `cf_o` takes `cf_next_o` (only when `cf_we_o` is high) at the next rising edge; with `exec_i` low both hold.
- R12: Op code 14 copies opnd into the result and op code 15 returns acc unchanged; neither writes the carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_i | input | 1 | Capture result and carry on the next edge |
| op_i | input | 4 | Operation code |
| opnd_i | input | 4 | Second operand nibble |
| bit_sel_i | input | 2 | Accumulator bit index for the bit test |
| result_o | output | 4 | Combinational result nibble |
| cf_next_o | output | 1 | Carry value the operation produces |
| cf_we_o | output | 1 | High when the operation writes the carry |
| zero_o | output | 1 | Result is zero |
| bit_o | output | 1 | Selected accumulator bit |
| acc_o | output | 4 | Registered accumulator |
| cf_o | output | 1 | Registered carry flag |

## Verification
The combinational outputs (`result_o`, `cf_next_o`, `cf_we_o`, `zero_o`, `bit_o`) respond in the same cycle the operation is driven, so the bench drives on the falling edge and samples them one nanosecond later, still ahead of the rising edge that would commit them. The registered `acc_o` and `cf_o` are due one rising edge after an executed operation and are sampled one nanosecond past that edge, and a following idle cycle with `exec_i` low is sampled the same way to confirm both hold. Every operation is swept across all accumulator values, all operands and both carry states, with the expected values restated arithmetically in the bench.

// File: rtl/nib_alu_pkg.sv
package nib_alu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_INC  = 4'd7,
    OP_DEC  = 4'd8,
    OP_RL   = 4'd9,
    OP_RLC  = 4'd10,
    OP_RR   = 4'd11,
    OP_RRC  = 4'd12,
    OP_DAA  = 4'd13,
    OP_PASS = 4'd14,
    OP_NOP  = 4'd15
  } alu_op_e;
endpackage

// File: rtl/nib_alu_addsub.sv
module nib_alu_addsub #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         invert_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  function automatic logic [W:0] add_full(input logic [W-1:0] x,
                                          input logic [W-1:0] y,
                                          input logic         c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  logic [W-1:0] b_eff;
  logic [W:0]   total;

  always_comb begin
    b_eff  = invert_i ? ~b_i : b_i;
    total  = add_full(a_i, b_eff, cin_i);
    sum_o  = total[W-1:0];
    cout_o = total[W];
  end
endmodule

// File: rtl/nib_alu_rotate.sv
module nib_alu_rotate #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic         cin_i,
  input  logic         left_i,
  input  logic         thru_i,
  output logic [W-1:0] res_o,
  output logic         cout_o
);
  logic [W-1:0] up_v;
  logic [W-1:0] dn_v;
  logic         fill_up;
  logic         fill_dn;

  assign fill_up = thru_i ? cin_i : a_i[W-1];
  assign fill_dn = thru_i ? cin_i : a_i[0];

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      assign up_v[i] = fill_up;
    end else begin : g_up
      assign up_v[i] = a_i[i-1];
    end
    if (i == W - 1) begin : g_msb
      assign dn_v[i] = fill_dn;
    end else begin : g_dn
      assign dn_v[i] = a_i[i+1];
    end
  end

  assign res_o  = left_i ? up_v : dn_v;
  assign cout_o = left_i ? a_i[W-1] : a_i[0];
endmodule

// File: rtl/nib_alu_decadj.sv
module nib_alu_decadj #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic         cf_i,
  output logic [W-1:0] res_o,
  output logic         adj_o
);
  localparam logic [W-1:0] DIGIT_MAX = W'(9);
  localparam logic [W-1:0] FIXUP     = W'(6);

  assign adj_o = (a_i > DIGIT_MAX) || cf_i;
  assign res_o = adj_o ? a_i + FIXUP : a_i;
endmodule

// File: rtl/nib_alu_core.sv
module nib_alu_core
  import nib_alu_pkg::*;
#(
  parameter int W     = 4,
  parameter int SEL_W = (W > 1) ? $clog2(W) : 1
) (
  input  alu_op_e          op_i,
  input  logic [W-1:0]     acc_i,
  input  logic [W-1:0]     opnd_i,
  input  logic             cf_i,
  input  logic [SEL_W-1:0] bit_sel_i,
  output logic [W-1:0]     result_o,
  output logic             cf_next_o,
  output logic             cf_we_o,
  output logic             zero_o,
  output logic             bit_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic         is_sub;
  logic         as_cin;
  logic [W-1:0] as_sum;
  logic         as_cout;
  logic         rot_left;
  logic         rot_thru;
  logic [W-1:0] rot_res;
  logic         rot_cout;
  logic [W-1:0] da_res;
  logic         da_adj;

  always_comb begin
    is_sub = (op_i == OP_SUB) || (op_i == OP_SBC);
    unique case (op_i)
      OP_ADC, OP_SBC: as_cin = cf_i;
      OP_SUB:         as_cin = 1'b1;
      default:        as_cin = 1'b0;
    endcase
    rot_left = (op_i == OP_RL) || (op_i == OP_RLC);
    rot_thru = (op_i == OP_RLC) || (op_i == OP_RRC);
  end

  nib_alu_addsub #(.W(W)) u_addsub (
    .a_i      (acc_i),
    .b_i      (opnd_i),
    .invert_i (is_sub),
    .cin_i    (as_cin),
    .sum_o    (as_sum),
    .cout_o   (as_cout)
  );

  nib_alu_rotate #(.W(W)) u_rotate (
    .a_i    (acc_i),
    .cin_i  (cf_i),
    .left_i (rot_left),
    .thru_i (rot_thru),
    .res_o  (rot_res),
    .cout_o (rot_cout)
  );

  nib_alu_decadj #(.W(W)) u_decadj (
    .a_i   (acc_i),
    .cf_i  (cf_i),
    .res_o (da_res),
    .adj_o (da_adj)
  );

  always_comb begin
    result_o  = acc_i;
    cf_next_o = cf_i;
    cf_we_o   = 1'b0;
    unique case (op_i)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
        result_o  = as_sum;
        cf_next_o = as_cout;
        cf_we_o   = 1'b1;
      end
      OP_AND:  result_o = acc_i & opnd_i;
      OP_OR:   result_o = acc_i | opnd_i;
      OP_XOR:  result_o = acc_i ^ opnd_i;
      OP_INC:  result_o = acc_i + ONE;
      OP_DEC:  result_o = acc_i - ONE;
      OP_RL, OP_RLC, OP_RR, OP_RRC: begin
        result_o  = rot_res;
        cf_next_o = rot_cout;
        cf_we_o   = 1'b1;
      end
      OP_DAA: begin
        result_o  = da_res;
        cf_next_o = 1'b1;
        cf_we_o   = da_adj;
      end
      OP_PASS: result_o = opnd_i;
      default: result_o = acc_i;
    endcase
  end

  assign zero_o = (result_o == '0);
  assign bit_o  = acc_i[bit_sel_i];
endmodule

// File: rtl/nib_acc_alu.sv
module nib_acc_alu
  import nib_alu_pkg::*;
#(
  parameter int W     = 4,
  parameter int SEL_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exec_i,
  input  logic [OP_W-1:0]  op_i,
  input  logic [W-1:0]     opnd_i,
  input  logic [SEL_W-1:0] bit_sel_i,
  output logic [W-1:0]     result_o,
  output logic             cf_next_o,
  output logic             cf_we_o,
  output logic             zero_o,
  output logic             bit_o,
  output logic [W-1:0]     acc_o,
  output logic             cf_o
);
  logic [W-1:0] acc_q;
  logic         cf_q;
  logic         acc_load;
  logic         carry_load;

  nib_alu_core #(.W(W), .SEL_W(SEL_W)) u_core (
    .op_i      (alu_op_e'(op_i)),
    .acc_i     (acc_q),
    .opnd_i    (opnd_i),
    .cf_i      (cf_q),
    .bit_sel_i (bit_sel_i),
    .result_o  (result_o),
    .cf_next_o (cf_next_o),
    .cf_we_o   (cf_we_o),
    .zero_o    (zero_o),
    .bit_o     (bit_o)
  );

  assign acc_load   = exec_i;
  assign carry_load = exec_i & cf_we_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cf_q  <= 1'b0;
    end else begin
      if (acc_load)   acc_q <= result_o;
      if (carry_load) cf_q  <= cf_next_o;
    end
  end

  assign acc_o = acc_q;
  assign cf_o  = cf_q;
endmodule

// File: rtl/nib_acc_alu_chk.sv
module nib_acc_alu_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         acc_load,
  input logic         carry_load,
  input logic [3:0]   op_i,
  input logic [W-1:0] result_o,
  input logic         cf_next_o,
  input logic         cf_we_o,
  input logic         zero_o,
  input logic [W-1:0] acc_o,
  input logic         cf_o
);
  AST_ACC_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_load |=> acc_o == $past(result_o)); // R11
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_load |=> $stable(acc_o) && $stable(cf_o)); // R11
  AST_CARRY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_load && !cf_we_o) |=> cf_o == $past(cf_o)); // R4
  AST_INCDEC_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd7 || op_i == 4'd8) |-> !cf_we_o); // R5
  AST_DAA_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_load && op_i == 4'd13 && cf_o) |=> cf_o); // R8
  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    zero_o |-> result_o == '0); // R9
  AST_CARRY_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    carry_load |=> cf_o == $past(cf_next_o)); // R11
endmodule

bind nib_acc_alu nib_acc_alu_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_load   (acc_load),
  .carry_load (carry_load),
  .op_i       (op_i),
  .result_o   (result_o),
  .cf_next_o  (cf_next_o),
  .cf_we_o    (cf_we_o),
  .zero_o     (zero_o),
  .acc_o      (acc_o),
  .cf_o       (cf_o)
);

// File: tb/nib_acc_alu_bench.sv
`timescale 1ns/1ps
module nib_acc_alu_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       exec_i = 1'b0;
  logic [3:0] op_i = 4'd15;
  logic [3:0] opnd_i = 4'd0;
  logic [1:0] bit_sel_i = 2'd0;
  logic [3:0] result_o;
  logic       cf_next_o;
  logic       cf_we_o;
  logic       zero_o;
  logic       bit_o;
  logic [3:0] acc_o;
  logic       cf_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nib_acc_alu u_nib_acc_alu (
    .clk       (clk),
    .rst_n     (rst_n),
    .exec_i    (exec_i),
    .op_i      (op_i),
    .opnd_i    (opnd_i),
    .bit_sel_i (bit_sel_i),
    .result_o  (result_o),
    .cf_next_o (cf_next_o),
    .cf_we_o   (cf_we_o),
    .zero_o    (zero_o),
    .bit_o     (bit_o),
    .acc_o     (acc_o),
    .cf_o      (cf_o)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic drive(input int op, input int opnd, input bit ex);
    @(negedge clk);
    op_i      = 4'(op);
    opnd_i    = 4'(opnd);
    bit_sel_i = 2'(opnd);
    exec_i    = ex;
  endtask

  function automatic string tag_of(input int op);
    case (op)
      0, 1:          return "R2";
      2, 3:          return "R3";
      4, 5, 6:       return "R4";
      7, 8:          return "R5";
      9, 11:         return "R6";
      10, 12:        return "R7";
      13:            return "R8";
      default:       return "R12";
    endcase
  endfunction

  // Arithmetic restatement of the operation table: returns {we, carry, result}
  function automatic int model(input int op, input int a, input int b, input int c);
    int s; int r; int nc; int we;
    r = a; nc = c; we = 0;
    case (op)
      0: begin s = a + b;          r = s % 16; nc = s / 16; we = 1; end
      1: begin s = a + b + c;      r = s % 16; nc = s / 16; we = 1; end
      2: begin s = a + 15 - b + 1; r = s % 16; nc = s / 16; we = 1; end
      3: begin s = a + 15 - b + c; r = s % 16; nc = s / 16; we = 1; end
      4: r = a & b;
      5: r = a | b;
      6: r = a ^ b;
      7: r = (a + 1) % 16;
      8: r = (a + 15) % 16;
      9:  begin r = (a * 2) % 16 + a / 8;  nc = a / 8;  we = 1; end
      10: begin r = (a * 2) % 16 + c;      nc = a / 8;  we = 1; end
      11: begin r = a / 2 + (a % 2) * 8;   nc = a % 2;  we = 1; end
      12: begin r = a / 2 + c * 8;         nc = a % 2;  we = 1; end
      13: if (a > 9 || c == 1) begin r = (a + 6) % 16; nc = 1; we = 1; end
      14: r = b;
      default: r = a;
    endcase
    return we * 32 + nc * 16 + r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1;
    chk("R1", "acc in reset", int'(acc_o), 0);
    chk("R1", "cf in reset", int'(cf_o), 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1", "acc after release", int'(acc_o), 0);
    chk("R1", "cf after release", int'(cf_o), 0);

    for (int op = 0; op < 16; op++) begin
      for (int c = 0; c < 2; c++) begin
        for (int a = 0; a < 16; a++) begin
          for (int b = 0; b < 16; b++) begin
            int m; int er; int ec; int ew; string t;
            m  = model(op, a, b, c);
            er = m % 16;
            ec = (m / 16) % 2;
            ew = m / 32;
            t  = tag_of(op);
            drive(14, 0, 1'b1);
            drive(c ? 2 : 0, 0, 1'b1);
            drive(14, a, 1'b1);
            drive(op, b, 1'b1);
            #1;
            chk(t, "result", int'(result_o), er);
            chk(t, "carry write enable", int'(cf_we_o), ew);
            if (ew == 1) chk(t, "next carry", int'(cf_next_o), ec);
            chk("R9", "zero flag", int'(zero_o), (er == 0) ? 1 : 0);
            chk("R10", "bit test", int'(bit_o), (a >> (b % 4)) % 2);
            @(posedge clk); #1;
            chk("R11", "acc after exec", int'(acc_o), er);
            chk("R11", "cf after exec", int'(cf_o), (ew == 1) ? ec : c);
            drive((op + 5) % 16, 15 - b, 1'b0);
            @(posedge clk); #1;
            chk("R11", "acc held when idle", int'(acc_o), er);
            chk("R11", "cf held when idle", int'(cf_o), (ew == 1) ? ec : c);
          end
        end
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule